// File: doc/BRIEF.md
# Dual-Context Configuration Register Bank

This block keeps two full sets of configuration state for a content-addressable array: a control word, a pair of segment counters, an address pointer, a per-set comparison mask, and the persistent source and destination path selectors. One set is active at a time. Every command acts on the active set only, so a foreground filtering setup and a background purge setup can be preloaded and swapped with a single switch command. Each switch emits a one-cycle pulse that the array uses to clear its match state.

Wide words are carried over a narrow command argument one segment at a time. A write counter and a read counter step through the segments of the active set's destination and source, and wrap at the last segment. A wrapping write marks a completed word. When the path points at memory, a wrap also steps the address pointer up or down as the control word selects, modulo the array depth. A second mask register is shared by both sets. It can be loaded segment by segment or shifted one bit left or right per command.

Top module: `cfgbank_top`

## Requirements
- R1: After reset the active set is 0 and, in both sets, the control word, address, selectors, both segment counters and mask 1 are zero; mask 2, `rd_data_o`, `match_clr_o` and `word_done_o` are zero.
- R2: Op 1 (switch) makes set `cmd_arg[0]` active. Every other op changes only the active set (and the shared mask 2), and the inactive set keeps its contents.
- R3: `match_clr_o` is high for exactly the one cycle after each accepted switch command, and is low otherwise.
- R4: Op 5 (data write) with destination code 1 stores `cmd_arg` into segment k of the active set's mask 1, where k is the write counter and segment k is bits 16k+15 down to 16k.
- R5: Each op 5 advances the write counter by one and wraps it from NSEG-1 to 0. `word_done_o` is high in the cycle after a wrapping write.
- R6: Each op 6 (data read) advances the read counter, with the same wrap. `rd_data_o` shows segment (read counter) of mask 1 for source code 1, of mask 2 for source code 2, and 0 for codes 0 and 3.
- R7: On a wrapping write with destination code 3, or a wrapping read with source code 3, the address steps by +1 when control bits [1:0] are 01 and by -1 when they are 10, wrapping modulo DEPTH. Any other value holds the address.
- R8: Op 3 loads the address from `cmd_arg` when the value is below DEPTH. A larger value leaves the address unchanged.
- R9: Op 4 sets source to `cmd_arg[1:0]` and destination to `cmd_arg[5:4]` and clears both counters. The selectors persist until the next op 4.
- R10: Mask 2 is shared by both sets. Op 5 with destination code 2 writes its segment at the write counter. Op 7 shifts it left by one bit and op 8 shifts it right by one bit, both with zero fill.
- R11: Op 9 loads the write counter from `cmd_arg[1:0]` and the read counter from `cmd_arg[9:8]`.
- R12: Op 2 loads the active control word from `cmd_arg[CTL_W-1:0]`. Op 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_arg | input | SEG_W | Command argument / data segment |
| active_ctx_o | output | 1 | Index of the active set |
| ctl_o | output | CTL_W | Active control word |
| addr_o | output | AW | Active address pointer |
| src_o | output | 2 | Active persistent source code |
| dst_o | output | 2 | Active persistent destination code |
| wseg_o | output | SI_W | Active write segment counter |
| rseg_o | output | SI_W | Active read segment counter |
| mask1_o | output | DATA_W | Active mask 1 |
| mask2_o | output | DATA_W | Shared mask 2 |
| rd_data_o | output | SEG_W | Segment read from the active source |
| match_clr_o | output | 1 | Match-state clear pulse after a switch |
| word_done_o | output | 1 | Full-word write completed |

## Verification
The bench builds the block with 64-bit words over 16-bit segments, which gives four segments per word, and a depth of 12. A depth that is not a power of two puts both address wrap points, 11 up to 0 and 0 down to 11, within a few commands. It also makes the out-of-range load of 12 a real case rather than an overflow of the pointer width. Four segments keep every counter wrap and the mask fill short enough that both sets, and the mask shared between them, are exercised in one pass.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_SWITCH = 4'd1,
    OP_CTL    = 4'd2,
    OP_ADDR   = 4'd3,
    OP_PSEL   = 4'd4,
    OP_WR     = 4'd5,
    OP_RD     = 4'd6,
    OP_M2L    = 4'd7,
    OP_M2R    = 4'd8,
    OP_SEGCTL = 4'd9
  } op_e;

  localparam logic [1:0] PATH_CMP = 2'd0;
  localparam logic [1:0] PATH_MK1 = 2'd1;
  localparam logic [1:0] PATH_MK2 = 2'd2;
  localparam logic [1:0] PATH_MEM = 2'd3;

  localparam logic [1:0] AMODE_INC = 2'b01;
  localparam logic [1:0] AMODE_DEC = 2'b10;
endpackage

// File: rtl/cfgbank_ctx.sv
module cfgbank_ctx
  import cfgbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  parameter int DEPTH  = 1024,
  parameter int CTL_W  = 16,
  localparam int NSEG  = DATA_W / SEG_W,
  localparam int SI_W  = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_e               op,
  input  logic [SEG_W-1:0]  arg,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [AW-1:0]     addr_q,
  output logic [1:0]        src_q,
  output logic [1:0]        dst_q,
  output logic [SI_W-1:0]   wseg_q,
  output logic [SI_W-1:0]   rseg_q,
  output logic [DATA_W-1:0] mask1_q,
  output logic              wr_wrap
);
  localparam logic [SI_W-1:0] LAST_SEG = SI_W'(NSEG - 1);
  localparam logic [AW-1:0]   LAST_ADR = AW'(DEPTH - 1);

  logic [CTL_W-1:0]  ctl_n;
  logic [AW-1:0]     addr_n;
  logic [1:0]        src_n, dst_n;
  logic [SI_W-1:0]   wseg_n, rseg_n;
  logic [DATA_W-1:0] mask1_n;
  logic              step;

  always_comb begin
    ctl_n   = ctl_q;
    addr_n  = addr_q;
    src_n   = src_q;
    dst_n   = dst_q;
    wseg_n  = wseg_q;
    rseg_n  = rseg_q;
    mask1_n = mask1_q;
    wr_wrap = 1'b0;
    step    = 1'b0;
    if (en) begin
      case (op)
        OP_CTL:  ctl_n = arg[CTL_W-1:0];
        OP_ADDR: if (32'(arg) < DEPTH) addr_n = arg[AW-1:0];
        OP_PSEL: begin
          src_n  = arg[1:0];
          dst_n  = arg[5:4];
          wseg_n = '0;
          rseg_n = '0;
        end
        OP_SEGCTL: begin
          wseg_n = arg[SI_W-1:0];
          rseg_n = arg[8 +: SI_W];
        end
        OP_WR: begin
          if (dst_q == PATH_MK1) mask1_n[int'(wseg_q)*SEG_W +: SEG_W] = arg;
          if (wseg_q == LAST_SEG) begin
            wseg_n  = '0;
            wr_wrap = 1'b1;
            step    = (dst_q == PATH_MEM);
          end else begin
            wseg_n = wseg_q + 1'b1;
          end
        end
        OP_RD: begin
          if (rseg_q == LAST_SEG) begin
            rseg_n = '0;
            step   = (src_q == PATH_MEM);
          end else begin
            rseg_n = rseg_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (step) begin
      if (ctl_q[1:0] == AMODE_INC)
        addr_n = (addr_q == LAST_ADR) ? '0 : addr_q + 1'b1;
      else if (ctl_q[1:0] == AMODE_DEC)
        addr_n = (addr_q == '0) ? LAST_ADR : addr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      addr_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      wseg_q  <= '0;
      rseg_q  <= '0;
      mask1_q <= '0;
    end else if (en) begin
      ctl_q   <= ctl_n;
      addr_q  <= addr_n;
      src_q   <= src_n;
      dst_q   <= dst_n;
      wseg_q  <= wseg_n;
      rseg_q  <= rseg_n;
      mask1_q <= mask1_n;
    end
  end

  p_addr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(addr_q) < DEPTH);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({ctl_q, addr_q, src_q, dst_q, wseg_q, rseg_q, mask1_q}));

  p_wseg_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_WR && wseg_q == LAST_SEG) |=> (wseg_q == '0));

  p_bad_addr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_ADDR && 32'(arg) >= DEPTH) |=> $stable(addr_q));
endmodule

// File: rtl/cfgbank_mask2.sv
module cfgbank_mask2 #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  localparam int NSEG  = DATA_W / SEG_W,
  localparam int SI_W  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SI_W-1:0]   seg,
  input  logic [SEG_W-1:0]  data,
  input  logic              shl,
  input  logic              shr,
  output logic [DATA_W-1:0] mask_q
);
  logic [DATA_W-1:0] mask_n;
  logic              upd;

  always_comb begin
    mask_n = mask_q;
    if (wr_en)    mask_n[int'(seg)*SEG_W +: SEG_W] = data;
    else if (shl) mask_n = {mask_q[DATA_W-2:0], 1'b0};
    else if (shr) mask_n = {1'b0, mask_q[DATA_W-1:1]};
    upd = wr_en | shl | shr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask_q <= '0;
    else if (upd) mask_q <= mask_n;
  end

  p_shift_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shl && !wr_en) |=> (mask_q == ($past(mask_q) << 1)));

  p_shift_right_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shr && !wr_en && !shl) |=> (mask_q == ($past(mask_q) >> 1)));
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  parameter int DEPTH  = 1024,
  parameter int CTL_W  = 16,
  localparam int NSEG  = DATA_W / SEG_W,
  localparam int SI_W  = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [SEG_W-1:0]  cmd_arg,
  output logic              active_ctx_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [AW-1:0]     addr_o,
  output logic [1:0]        src_o,
  output logic [1:0]        dst_o,
  output logic [SI_W-1:0]   wseg_o,
  output logic [SI_W-1:0]   rseg_o,
  output logic [DATA_W-1:0] mask1_o,
  output logic [DATA_W-1:0] mask2_o,
  output logic [SEG_W-1:0]  rd_data_o,
  output logic              match_clr_o,
  output logic              word_done_o
);
  op_e               op;
  logic              active_q, active_n;
  logic              clr_q, clr_n, done_q, done_n;
  logic              is_switch;

  logic [CTL_W-1:0]  ctl_a   [2];
  logic [AW-1:0]     addr_a  [2];
  logic [1:0]        src_a   [2];
  logic [1:0]        dst_a   [2];
  logic [SI_W-1:0]   wseg_a  [2];
  logic [SI_W-1:0]   rseg_a  [2];
  logic [DATA_W-1:0] mask1_a [2];
  logic              wrap_a  [2];

  assign op        = op_e'(cmd_op);
  assign is_switch = cmd_valid && (op == OP_SWITCH);

  for (genvar c = 0; c < 2; c++) begin : g_ctx
    cfgbank_ctx #(
      .DATA_W(DATA_W), .SEG_W(SEG_W), .DEPTH(DEPTH), .CTL_W(CTL_W)
    ) u_ctx (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cmd_valid && (active_q == 1'(c))),
      .op      (op),
      .arg     (cmd_arg),
      .ctl_q   (ctl_a[c]),
      .addr_q  (addr_a[c]),
      .src_q   (src_a[c]),
      .dst_q   (dst_a[c]),
      .wseg_q  (wseg_a[c]),
      .rseg_q  (rseg_a[c]),
      .mask1_q (mask1_a[c]),
      .wr_wrap (wrap_a[c])
    );
  end

  cfgbank_mask2 #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_mask2 (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cmd_valid && op == OP_WR && dst_a[active_q] == PATH_MK2),
    .seg    (wseg_a[active_q]),
    .data   (cmd_arg),
    .shl    (cmd_valid && op == OP_M2L),
    .shr    (cmd_valid && op == OP_M2R),
    .mask_q (mask2_o)
  );

  always_comb begin
    active_n = is_switch ? cmd_arg[0] : active_q;
    clr_n    = is_switch;
    done_n   = cmd_valid && wrap_a[active_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      clr_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_n;
      clr_q    <= clr_n;
      done_q   <= done_n;
    end
  end

  always_comb begin
    case (src_a[active_q])
      PATH_MK1: rd_data_o = mask1_a[active_q][int'(rseg_a[active_q])*SEG_W +: SEG_W];
      PATH_MK2: rd_data_o = mask2_o[int'(rseg_a[active_q])*SEG_W +: SEG_W];
      default:  rd_data_o = '0;
    endcase
  end

  assign active_ctx_o = active_q;
  assign ctl_o        = ctl_a[active_q];
  assign addr_o       = addr_a[active_q];
  assign src_o        = src_a[active_q];
  assign dst_o        = dst_a[active_q];
  assign wseg_o       = wseg_a[active_q];
  assign rseg_o       = rseg_a[active_q];
  assign mask1_o      = mask1_a[active_q];
  assign match_clr_o  = clr_q;
  assign word_done_o  = done_q;

  p_switch_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_switch |=> (match_clr_o && active_ctx_o == $past(cmd_arg[0])));

  p_no_stray_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_switch |=> !match_clr_o);

  p_ctx_only_by_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_switch |=> $stable(active_ctx_o));
endmodule

// File: tb/cfgbank_top_test.sv
`timescale 1ns/1ps
module cfgbank_top_test;
  localparam int DATA_W = 64;
  localparam int SEG_W  = 16;
  localparam int DEPTH  = 12;
  localparam int CTL_W  = 16;
  localparam int AW     = 4;
  localparam int SI_W   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [3:0]        cmd_op = '0;
  logic [SEG_W-1:0]  cmd_arg = '0;
  logic              active_ctx_o;
  logic [CTL_W-1:0]  ctl_o;
  logic [AW-1:0]     addr_o;
  logic [1:0]        src_o, dst_o;
  logic [SI_W-1:0]   wseg_o, rseg_o;
  logic [DATA_W-1:0] mask1_o, mask2_o;
  logic [SEG_W-1:0]  rd_data_o;
  logic              match_clr_o, word_done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cfgbank_top #(.DATA_W(DATA_W), .SEG_W(SEG_W), .DEPTH(DEPTH), .CTL_W(CTL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .active_ctx_o(active_ctx_o), .ctl_o(ctl_o), .addr_o(addr_o), .src_o(src_o),
    .dst_o(dst_o), .wseg_o(wseg_o), .rseg_o(rseg_o), .mask1_o(mask1_o),
    .mask2_o(mask2_o), .rd_data_o(rd_data_o), .match_clr_o(match_clr_o),
    .word_done_o(word_done_o)
  );

  localparam logic [3:0] NOP = 0, SW = 1, CTL = 2, ADR = 3, PSEL = 4,
                         WR = 5, RD = 6, M2L = 7, M2R = 8, SEGC = 9;

  // op, arg, expected ctx, addr, wseg, rseg, word_done, requirement
  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] arg;
    logic        ctx;
    logic [3:0]  addr;
    logic [1:0]  wseg;
    logic [1:0]  rseg;
    logic        done;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    {CTL,  16'h0001, 1'b0, 4'd0,  2'd0, 2'd0, 1'b0, 4'd12}, // R12 increment mode
    {ADR,  16'd10,   1'b0, 4'd10, 2'd0, 2'd0, 1'b0, 4'd8},  // R8
    {PSEL, 16'h0030, 1'b0, 4'd10, 2'd0, 2'd0, 1'b0, 4'd9},  // R9 dst memory
    {WR,   16'h1234, 1'b0, 4'd10, 2'd1, 2'd0, 1'b0, 4'd5},
    {WR,   16'h1234, 1'b0, 4'd10, 2'd2, 2'd0, 1'b0, 4'd5},
    {WR,   16'h1234, 1'b0, 4'd10, 2'd3, 2'd0, 1'b0, 4'd5},
    {WR,   16'h1234, 1'b0, 4'd11, 2'd0, 2'd0, 1'b1, 4'd7},  // R7 step up
    {WR,   16'h1234, 1'b0, 4'd11, 2'd1, 2'd0, 1'b0, 4'd5},
    {WR,   16'h1234, 1'b0, 4'd11, 2'd2, 2'd0, 1'b0, 4'd5},
    {WR,   16'h1234, 1'b0, 4'd11, 2'd3, 2'd0, 1'b0, 4'd5},
    {WR,   16'h1234, 1'b0, 4'd0,  2'd0, 2'd0, 1'b1, 4'd7},  // R7 wrap 11 -> 0
    {ADR,  16'd12,   1'b0, 4'd0,  2'd0, 2'd0, 1'b0, 4'd8},  // R8 ignored
    {CTL,  16'h0002, 1'b0, 4'd0,  2'd0, 2'd0, 1'b0, 4'd12}, // R12 decrement mode
    {PSEL, 16'h0003, 1'b0, 4'd0,  2'd0, 2'd0, 1'b0, 4'd9},  // R9 src memory
    {RD,   16'h0000, 1'b0, 4'd0,  2'd0, 2'd1, 1'b0, 4'd6},
    {RD,   16'h0000, 1'b0, 4'd0,  2'd0, 2'd2, 1'b0, 4'd6},
    {RD,   16'h0000, 1'b0, 4'd0,  2'd0, 2'd3, 1'b0, 4'd6},
    {RD,   16'h0000, 1'b0, 4'd11, 2'd0, 2'd0, 1'b0, 4'd7},  // R7 wrap 0 -> 11
    {SW,   16'h0001, 1'b1, 4'd0,  2'd0, 2'd0, 1'b0, 4'd2},  // R2
    {ADR,  16'd5,    1'b1, 4'd5,  2'd0, 2'd0, 1'b0, 4'd8},
    {SW,   16'h0000, 1'b0, 4'd11, 2'd0, 2'd0, 1'b0, 4'd2},  // R2 set 0 kept
    {CTL,  16'h0000, 1'b0, 4'd11, 2'd0, 2'd0, 1'b0, 4'd12},
    {RD,   16'h0000, 1'b0, 4'd11, 2'd0, 2'd1, 1'b0, 4'd7},
    {RD,   16'h0000, 1'b0, 4'd11, 2'd0, 2'd2, 1'b0, 4'd7},
    {RD,   16'h0000, 1'b0, 4'd11, 2'd0, 2'd3, 1'b0, 4'd7},
    {RD,   16'h0000, 1'b0, 4'd11, 2'd0, 2'd0, 1'b0, 4'd7}   // R7 hold mode
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [3:0] op, logic [15:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_arg   = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = NOP;
    cmd_arg   = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ctx",   64'(active_ctx_o), 0);
    chk("R1 ctl",   64'(ctl_o), 0);
    chk("R1 addr",  64'(addr_o), 0);
    chk("R1 sel",   64'({src_o, dst_o, wseg_o, rseg_o}), 0);
    chk("R1 masks", mask1_o | mask2_o, 0);
    chk("R1 outs",  64'({rd_data_o, match_clr_o, word_done_o}), 0);

    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i].op, VEC[i].arg);
      chk($sformatf("R%0d row %0d ctx", VEC[i].req, i), 64'(active_ctx_o), 64'(VEC[i].ctx));
      chk($sformatf("R%0d row %0d addr", VEC[i].req, i), 64'(addr_o), 64'(VEC[i].addr));
      chk($sformatf("R%0d row %0d seg", VEC[i].req, i), 64'({wseg_o, rseg_o}),
          64'({VEC[i].wseg, VEC[i].rseg}));
      chk($sformatf("R%0d row %0d done", VEC[i].req, i), 64'(word_done_o), 64'(VEC[i].done));
    end

    do_reset();
    chk("R1 after re-reset", 64'({active_ctx_o, addr_o, ctl_o}), 0);

    cmd(SW, 16'h0000);
    chk("R3 clear pulse", 64'(match_clr_o), 1);
    cmd(NOP, 16'h0000);
    chk("R3 pulse ends", 64'(match_clr_o), 0);
    chk("R12 nop keeps state", 64'({ctl_o, addr_o}), 0);

    cmd(PSEL, 16'h0010);
    cmd(WR, 16'h1111);
    chk("R5 no early done", 64'(word_done_o), 0);
    cmd(WR, 16'h2222);
    cmd(WR, 16'h3333);
    cmd(WR, 16'h4444);
    chk("R4 mask1 fill", mask1_o, 64'h4444_3333_2222_1111);
    chk("R5 word done", 64'(word_done_o), 1);

    cmd(SW, 16'h0001);
    chk("R2 other set mask1", mask1_o, 0);
    cmd(PSEL, 16'h0010);
    cmd(WR, 16'hAAAA);
    chk("R4 set1 mask1", mask1_o, 64'h0000_0000_0000_AAAA);
    cmd(SW, 16'h0000);
    chk("R2 set0 mask1 kept", mask1_o, 64'h4444_3333_2222_1111);

    cmd(PSEL, 16'h0001);
    chk("R6 read seg0", 64'(rd_data_o), 64'h1111);
    cmd(RD, 16'h0000);
    chk("R6 read seg1", 64'(rd_data_o), 64'h2222);
    cmd(SEGC, 16'h0300);
    chk("R11 counters", 64'({wseg_o, rseg_o}), 64'({2'd0, 2'd3}));
    chk("R11 read seg3", 64'(rd_data_o), 64'h4444);

    cmd(PSEL, 16'h0020);
    cmd(WR, 16'h8001);
    cmd(WR, 16'h0000);
    cmd(WR, 16'h0000);
    cmd(WR, 16'h8000);
    chk("R10 mask2 fill", mask2_o, 64'h8000_0000_0000_8001);
    chk("R4 mask1 untouched", mask1_o, 64'h4444_3333_2222_1111);
    cmd(M2L, 16'h0000);
    chk("R10 shift left", mask2_o, 64'h0000_0000_0001_0002);
    cmd(M2R, 16'h0000);
    chk("R10 shift right", mask2_o, 64'h0000_0000_0000_8001);
    cmd(PSEL, 16'h0002);
    chk("R6 read mask2", 64'(rd_data_o), 64'h8001);

    cmd(SW, 16'h0001);
    chk("R10 mask2 shared", mask2_o, 64'h0000_0000_0000_8001);
    cmd(CTL, 16'hBEEF);
    chk("R12 ctl load", 64'(ctl_o), 64'hBEEF);
    cmd(PSEL, 16'h0000);
    chk("R6 code0 reads zero", 64'(rd_data_o), 0);
    cmd(SW, 16'h0000);
    chk("R2 set0 ctl kept", 64'(ctl_o), 0);
    chk("R9 selectors persist", 64'({src_o, dst_o}), 64'({2'd2, 2'd0}));

    finish_run();
  end
endmodule